// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises characters onto a single asynchronous line. A holding register accepts one character (eight data bits plus an optional ninth) while a separate shift register drives the line. A character therefore waits in the holding register while the previous frame is still going out. A bit-rate strobe from outside paces the line. Each strobe ends the current bit slot and starts the next, so every bit lasts exactly one strobe period.

Two status flags report progress. `hold_empty` tells the host that a new character may be written. `line_done` tells it that the last frame has fully left the line and nothing is waiting. Raising the enable first sends one preamble character of all ones. While the break control is held, the block sends frames of all zeros. Lowering the enable lets the frame in flight finish, and only then does the line rest high.

Top module: `serial_tx_dbuf`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1, `hold_empty` is 1 and `line_done` is 1.
- R2: An 8-bit frame is ten slots in this order: a 0 start bit, then `wr_data[0]` through `wr_data[7]`, then a 1 stop bit. The line changes only on cycles where `bit_tick` is 1, and each slot spans one tick period.
- R3: With `nine_bit` = 1 when the frame is loaded, the frame is eleven slots. The `wr_bit8` value captured with the character goes out between `wr_data[7]` and the stop bit.
- R4: When `tx_en` goes from 0 to 1, the next frame sent is a preamble of all ones, lasting ten slots (eleven with `nine_bit` = 1). It is sent before any pending character or break.
- R5: A cycle with `wr_stb` = 1 makes both `hold_empty` and `line_done` 0 from the next cycle. `hold_empty` returns to 1 in the cycle after the tick at which the character enters the shift register.
- R6: A character that is waiting when a frame's last slot ends starts its start bit at that same tick. There is no idle slot between the two frames.
- R7: When a frame ends and nothing is waiting, `line_done` becomes 1 and `txd` stays 1. `line_done` is never 1 while `txd` is 0.
- R8: While `brk` = 1 and `tx_en` = 1, each new frame is all zeros, stop slot included. Break takes priority over a waiting character. That character is kept and goes out once `brk` is 0.
- R9: When `tx_en` is cleared during a frame, the frame still completes. Afterwards `txd` stays 1 and no waiting character is loaded until `tx_en` rises again, so `hold_empty` stays 0.
- R10: A write while `hold_empty` is 0 replaces the waiting character, and only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character data |
| wr_bit8 | input | 1 | Ninth data bit |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| tx_en | input | 1 | Transmit enable |
| brk | input | 1 | Send break frames |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a character |
| line_done | output | 1 | Line has finished and nothing is waiting |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse. They also assume that `nine_bit` and the data inputs are meaningful only at the cycles where the block samples them, and that reset is held for at least one clock edge. The stimulus raises the tick on one cycle in four, holds reset for several edges, and changes `nine_bit` only while the line is idle. Every input is changed on the falling clock edge. A behavioural queue model in the bench predicts the line and both flags on every cycle.

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  input  logic              nine_bit,
  input  logic              tx_en,
  input  logic              brk,
  output logic              txd,
  output logic              hold_empty,
  output logic              line_done
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LEN_S = CW'(FW - 1);
  localparam logic [CW-1:0] LEN_L = CW'(FW);

  logic [DATA_W-1:0] hold_q;
  logic              hold_b8;
  logic [FW-1:0]     sh;
  logic [CW-1:0]     cnt;
  logic              en_q, pre_q;

  logic busy, end_slot, pre_eff, ld_pre, ld_brk, ld_dat, ld_any;
  logic [CW-1:0] len;
  logic [FW-1:0] nxt_frame;

  assign busy     = cnt != '0;
  assign end_slot = bit_tick && cnt <= CW'(1);
  assign pre_eff  = pre_q || (tx_en && !en_q);
  assign ld_pre   = end_slot && tx_en && pre_eff;
  assign ld_brk   = end_slot && tx_en && !pre_eff && brk;
  assign ld_dat   = end_slot && tx_en && !pre_eff && !brk && !hold_empty;
  assign ld_any   = ld_pre || ld_brk || ld_dat;
  assign len      = nine_bit ? LEN_L : LEN_S;
  assign txd      = busy ? sh[0] : 1'b1;

  always_comb begin
    if (ld_pre)      nxt_frame = '1;
    else if (ld_brk) nxt_frame = '0;
    else             nxt_frame = {1'b1, nine_bit ? hold_b8 : 1'b1, hold_q, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (bit_tick) begin
      if (cnt > CW'(1)) begin
        sh  <= {1'b1, sh[FW-1:1]};
        cnt <= cnt - CW'(1);
      end else if (ld_any) begin
        sh  <= nxt_frame;
        cnt <= len;
      end else begin
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pre_q <= 1'b0;
    end else begin
      en_q  <= tx_en;
      pre_q <= tx_en && pre_eff && !ld_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_b8    <= 1'b0;
      hold_empty <= 1'b1;
    end else if (wr_stb) begin
      hold_q     <= wr_data;
      hold_b8    <= wr_bit8;
      hold_empty <= 1'b0;
    end else if (ld_dat) begin
      hold_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        line_done <= 1'b1;
    else if (wr_stb || ld_any)         line_done <= 1'b0;
    else if (end_slot && busy)         line_done <= 1'b1;
  end
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_stb,
  input logic tx_en,
  input logic txd,
  input logic hold_empty,
  input logic line_done,
  input logic busy
);
  p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> (txd && hold_empty && line_done));
  p_line_paced_r2: assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(txd));
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> (!hold_empty && !line_done));
  p_empty_holds_r5: assert property (@(posedge clk) disable iff (!rst_n) (hold_empty && !wr_stb) |=> hold_empty);
  p_done_high_r7: assert property (@(posedge clk) disable iff (!rst_n) line_done |-> txd);
  p_off_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !busy) |=> !busy);
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb), .tx_en(tx_en),
  .txd(txd), .hold_empty(hold_empty), .line_done(line_done), .busy(busy)
);

// File: tb/serial_tx_dbuf_bench.sv
`timescale 1ns/1ps
module serial_tx_dbuf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit8 = 1'b0;
  logic nine_bit = 1'b0;
  logic tx_en = 1'b0;
  logic brk = 1'b0;
  logic txd, hold_empty, line_done;

  always #5 clk = ~clk;

  serial_tx_dbuf u_serial_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .nine_bit(nine_bit), .tx_en(tx_en),
    .brk(brk), .txd(txd), .hold_empty(hold_empty), .line_done(line_done)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  int q[$];
  bit m_empty, m_done, m_b8, m_enq, m_pre;
  bit [7:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_empty = 1; m_done = 1; m_b8 = 0; m_data = 0; m_enq = 0; m_pre = 0;
    end else begin
      bit pre_now, loaded_pre, loaded_dat, loaded_any, ended_busy;
      int n;
      pre_now = m_pre || (tx_en && !m_enq);
      loaded_pre = 0; loaded_dat = 0; loaded_any = 0; ended_busy = 0;
      n = nine_bit ? 11 : 10;
      if (bit_tick) begin
        if (q.size() > 1) void'(q.pop_front());
        else begin
          ended_busy = q.size() > 0;
          q.delete();
          if (tx_en && pre_now) begin
            for (int i = 0; i < n; i++) q.push_back(1);
            loaded_pre = 1;
          end else if (tx_en && brk) begin
            for (int i = 0; i < n; i++) q.push_back(0);
          end else if (tx_en && !m_empty) begin
            q.push_back(0);
            for (int i = 0; i < 8; i++) q.push_back(m_data[i]);
            if (nine_bit) q.push_back(m_b8);
            q.push_back(1);
            loaded_dat = 1;
          end
          loaded_any = q.size() > 0;
        end
      end
      m_pre = tx_en && pre_now && !loaded_pre;
      m_enq = tx_en;
      if (loaded_dat) m_empty = 1;
      if (loaded_any) m_done = 0;
      else if (ended_busy) m_done = 1;
      if (wr_stb) begin
        m_data = wr_data; m_b8 = wr_bit8; m_empty = 0; m_done = 0;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("txd", txd, (q.size() > 0) ? q[0] : 1);
      chk("hold_empty", hold_empty, m_empty);
      chk("line_done", line_done, m_done);
    end
  end

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      bit_tick = (tc % 4 == 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, logic b8);
    @(negedge clk);
    wr_data = d; wr_bit8 = b8; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (m_done && q.size() == 0) break;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    cur_req = "R7";
    fails++;
    $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
    summary();
  end

  initial begin
    cyc(4);
    cur_req = "R1";
    chk("reset txd", txd, 1);
    chk("reset hold_empty", hold_empty, 1);
    chk("reset line_done", line_done, 1);
    rst_n = 1'b1;
    cyc(1);
    cmp_on = 1'b1;
    cyc(3);

    cur_req = "R4";
    tx_en = 1'b1;
    cyc(2);
    cur_req = "R2";
    wr(8'hA5, 1'b0);
    wait_done();

    cur_req = "R6";
    wr(8'h3C, 1'b0);
    cyc(6);
    wr(8'hC3, 1'b0);
    wait_done();

    cur_req = "R7";
    cyc(20);

    cur_req = "R3";
    nine_bit = 1'b1;
    wr(8'h81, 1'b1);
    wait_done();
    wr(8'h7E, 1'b0);
    wait_done();
    nine_bit = 1'b0;

    cur_req = "R10";
    wr(8'h11, 1'b0);
    cyc(5);
    wr(8'h22, 1'b0);
    wr(8'h44, 1'b0);
    wait_done();

    cur_req = "R8";
    brk = 1'b1;
    wr(8'h5A, 1'b0);
    cyc(90);
    brk = 1'b0;
    wait_done();

    cur_req = "R9";
    wr(8'hF0, 1'b0);
    cyc(14);
    tx_en = 1'b0;
    wr(8'h0F, 1'b0);
    cyc(120);
    cur_req = "R4";
    tx_en = 1'b1;
    wait_done();

    cur_req = "R5";
    wr(8'h99, 1'b0);
    cyc(3);
    wr(8'h66, 1'b0);
    wait_done();
    cyc(10);
    summary();
  end
endmodule